// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a system watchdog that forces a chip reset, or raises an interrupt, when software stops servicing it. Software programs a timeout constant and turns the watchdog on through a small register port. Once turned on, the watchdog cannot be turned off again by software. Only a hardware reset or a watchdog fault turns it off.

Countdown starts at the first correct feed after enabling. A correct feed is a key write followed at once by a second key write. The count then drops by one every fourth clock, because a fixed divide-by-4 prescaler sits in front of the down-counter. A count that runs out is a fault. A feed sequence that is broken is also a fault, and it takes effect at once. A fault sets a sticky timeout flag and stops the watchdog. Depending on the mode, the fault either sends a one-cycle reset request to the chip or holds an interrupt line high.

All logic is in one clock domain. Register reads are combinational from the address. Every read or write counts as a bus access.

Top module: `wdt_lockable`

## Requirements
- R1: After reset, the outputs are low. MODE (address 0) reads 0, TCONST (address 1) reads 0xFF, and VALUE (address 3) reads 0xFF.
- R2: A write to TCONST below 0xFF stores 0xFF. Any other value is stored exactly as written.
- R3: MODE bit 0 is the enable bit. Writing 1 sets it. Writing 0 does not clear it. Only reset or a fault clears it.
- R4: While enabled, VALUE does not change until the first valid feed.
- R5: A valid feed has two parts while enabled. First, the full word 0xAA is written to FEED (address 2). The very next bus access must then write 0x55 to FEED. A valid feed loads VALUE with TCONST and restarts the prescaler.
- R6: After a feed, VALUE equals TCONST − floor(k/4) once k clocks have passed.
- R7: The count expires exactly 4·(TCONST+1) clocks after the feed. Expiry is a fault.
- R8: While enabled, three cases are faults in the cycle of the access: any access other than writing 0x55 to FEED right after 0xAA; a write to FEED of any value except 0xAA when no sequence is pending; and a second write of 0xAA.
- R9: A fault sets the timeout flag (MODE bit 2 and the timeout_flag pin). It also clears enable and freezes VALUE.
- R10: With MODE bit 1 (reset mode) set at a fault, chip_rst_req is high for exactly the one cycle after the fault, and wdt_irq stays low.
- R11: With MODE bit 1 clear, wdt_irq stays high while the flag is set. Writing 1 to MODE bit 2 clears the flag.
- R12: The flag is not cleared by the watchdog's own reset request. It stays set until rst_n or a software clear.
- R13: While disabled, writes to FEED cause no fault and no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| wdt_irq | output | 1 | Watchdog interrupt, level |
| timeout_flag | output | 1 | Sticky watchdog fault flag |

## Verification
Some rules are checked by the assertions on every cycle:
- every fault sets the flag;
- enable falls only after a fault;
- counting implies enable;
- the reset request never lasts two cycles;
- the stored constant never drops below the minimum;
- the counter changes only on a prescaler tick or a load;
- a load always leaves the programmed constant in the counter;
- a pending feed never survives an access.

Other behaviour can only be shown by the bench's scenarios:
- the exact expiry cycle;
- readback of the countdown value;
- how each kind of feed sequence is classified;
- that enable is sticky;
- that feeds have no effect while the watchdog is disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE   = 2'd0,
        REG_TCONST = 2'd1,
        REG_FEED   = 2'd2,
        REG_VALUE  = 2'd3
    } wdt_reg_e;

    localparam int unsigned MODE_EN_BIT    = 0;
    localparam int unsigned MODE_RSTEN_BIT = 1;
    localparam int unsigned MODE_FLAG_BIT  = 2;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = run_i && (s_q.div == {PRE_W{1'b1}});
        if (restart_i) begin
            s_d.div = '0;
        end else if (run_i) begin
            s_d.div = s_q.div + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart_i) |=> !tick_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CW       = 32,
    parameter int unsigned MIN_LOAD = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);

    localparam logic [CW-1:0] RESET_CNT = CW'(MIN_LOAD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = tick_i && (s_q.cnt == '0);
        if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (tick_i && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= RESET_CNT;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(s_q.cnt));

    // R5
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.cnt == $past(load_val_i)));

endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
    import wdt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          access_i,
    input  logic          feed_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          feed_ok_o,
    output logic          feed_bad_o
);

    localparam logic [DW-1:0] FIRST_WORD  = DW'(KEY_FIRST);
    localparam logic [DW-1:0] SECOND_WORD = DW'(KEY_SECOND);

    typedef struct packed {
        logic armed;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        feed_ok_o  = 1'b0;
        feed_bad_o = 1'b0;
        if (!enable_i) begin
            s_d.armed = 1'b0;
        end else if (access_i) begin
            if (s_q.armed) begin
                s_d.armed = 1'b0;
                if (feed_wr_i && (wdata_i == SECOND_WORD)) begin
                    feed_ok_o = 1'b1;
                end else begin
                    feed_bad_o = 1'b1;
                end
            end else if (feed_wr_i) begin
                if (wdata_i == FIRST_WORD) begin
                    s_d.armed = 1'b1;
                end else begin
                    feed_bad_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    armed_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && access_i) |=> !s_q.armed);

    // R13
    disarmed_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !s_q.armed);

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
    import wdt_pkg::*;
#(
    parameter int unsigned DW     = 32,
    parameter int unsigned MIN_TC = 255,
    parameter int unsigned PRE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              chip_rst_req,
    output logic              wdt_irq,
    output logic              timeout_flag
);

    localparam logic [DW-1:0] MIN_TC_W = DW'(MIN_TC);

    typedef struct packed {
        logic          en;
        logic          rst_en;
        logic          flag;
        logic          run;
        logic          rst_req;
        logic [DW-1:0] tc;
    } top_state_t;

    top_state_t s_d, s_q;

    logic          access;
    logic          wr_mode;
    logic          wr_tc;
    logic          wr_feed;
    logic          feed_ok;
    logic          feed_bad;
    logic          tick;
    logic          expire;
    logic          fault;
    logic [DW-1:0] cnt;

    assign access  = bus_wr | bus_rd;
    assign wr_mode = bus_wr && (bus_addr == REG_MODE);
    assign wr_tc   = bus_wr && (bus_addr == REG_TCONST);
    assign wr_feed = bus_wr && (bus_addr == REG_FEED);

    wdt_feed_seq #(
        .DW (DW)
    ) i_feed_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (s_q.en),
        .access_i   (access),
        .feed_wr_i  (wr_feed),
        .wdata_i    (bus_wdata),
        .feed_ok_o  (feed_ok),
        .feed_bad_o (feed_bad)
    );

    wdt_prescaler #(
        .PRE_W (PRE_W)
    ) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.run),
        .restart_i (feed_ok),
        .tick_o    (tick)
    );

    wdt_counter #(
        .CW       (DW),
        .MIN_LOAD (MIN_TC)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (feed_ok),
        .load_val_i (s_q.tc),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    // A completed feed in the expiry cycle reloads instead of faulting.
    assign fault = feed_bad | (expire & ~feed_ok);

    always_comb begin
        s_d         = s_q;
        s_d.rst_req = fault & s_q.rst_en;

        if (wr_mode) begin
            s_d.rst_en = bus_wdata[MODE_RSTEN_BIT];
            if (bus_wdata[MODE_EN_BIT]) begin
                s_d.en = 1'b1;
            end
            if (bus_wdata[MODE_FLAG_BIT]) begin
                s_d.flag = 1'b0;
            end
        end

        if (wr_tc) begin
            s_d.tc = (bus_wdata < MIN_TC_W) ? MIN_TC_W : bus_wdata;
        end

        if (feed_ok) begin
            s_d.run = 1'b1;
        end

        if (fault) begin
            s_d.en   = 1'b0;
            s_d.run  = 1'b0;
            s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en      <= 1'b0;
            s_q.rst_en  <= 1'b0;
            s_q.flag    <= 1'b0;
            s_q.run     <= 1'b0;
            s_q.rst_req <= 1'b0;
            s_q.tc      <= MIN_TC_W;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_MODE: begin
                bus_rdata[MODE_EN_BIT]    = s_q.en;
                bus_rdata[MODE_RSTEN_BIT] = s_q.rst_en;
                bus_rdata[MODE_FLAG_BIT]  = s_q.flag;
            end
            REG_TCONST: bus_rdata = s_q.tc;
            REG_VALUE:  bus_rdata = cnt;
            default:    bus_rdata = '0;
        endcase
    end

    assign chip_rst_req = s_q.rst_req;
    assign wdt_irq      = s_q.flag & ~s_q.rst_en;
    assign timeout_flag = s_q.flag;

    // R9
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> s_q.flag);

    // R3
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.en) |-> $past(fault));

    // R9
    run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> s_q.en);

    // R10
    rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);

    // R2
    tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tc >= MIN_TC_W);

    // R12
    flag_survives_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst_req && !wr_mode) |=> timeout_flag);

endmodule

// File: tb/test_wdt_lockable.sv
`timescale 1ns/1ps
module test_wdt_lockable;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_TC   = 2'd1;
    localparam logic [1:0] A_FEED = 2'd2;
    localparam logic [1:0] A_VAL  = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        chip_rst_req;
    logic        wdt_irq;
    logic        timeout_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdt_lockable i_wdt_lockable (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .chip_rst_req (chip_rst_req),
        .wdt_irq      (wdt_irq),
        .timeout_flag (timeout_flag)
    );

    function automatic logic [31:0] exp_tc(input logic [31:0] w);
        return (w < 32'hFF) ? 32'hFF : w;
    endfunction

    function automatic logic [31:0] exp_val(input logic [31:0] tc, input int k);
        return tc - 32'(k / 4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_feed();
        bus_write(A_FEED, 32'hAA);
        bus_write(A_FEED, 32'h55);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 chip_rst_req", 32'(chip_rst_req), 0);
        check("R1 wdt_irq", 32'(wdt_irq), 0);
        bus_read(A_MODE, v); check("R1 MODE", v, 0);
        bus_read(A_TC, v);   check("R1 TCONST", v, 32'hFF);
        bus_read(A_VAL, v);  check("R1 VALUE", v, 32'hFF);

        // R2 clamp
        bus_write(A_TC, 32'd5);    bus_read(A_TC, v); check("R2 below min", v, 32'hFF);
        bus_write(A_TC, 32'hFF);   bus_read(A_TC, v); check("R2 at min", v, 32'hFF);
        bus_write(A_TC, 32'h100);  bus_read(A_TC, v); check("R2 above min", v, 32'h100);

        // R13 feeds while disabled do nothing
        bus_write(A_FEED, 32'h12);
        do_feed();
        bus_read(A_MODE, v); check("R13 no fault", v, 0);
        bus_read(A_VAL, v);  check("R13 no reload", v, 32'hFF);

        // R3 sticky enable, R4 idle before first feed
        bus_write(A_MODE, 32'h1);
        bus_write(A_MODE, 32'h0);
        bus_read(A_MODE, v); check("R3 enable kept", v, 32'h1);
        idle(50);
        bus_read(A_VAL, v); check("R4 no count before feed", v, 32'hFF);

        // R5, R6 feed and countdown
        do_feed();
        bus_read(A_VAL, v); check("R5 load", v, 32'h100);
        idle(9);
        bus_read(A_VAL, v); check("R6 countdown", v, exp_val(32'h100, 10));

        // R5 refresh prevents expiry
        bus_write(A_TC, 32'hFF);
        do_feed(); idle(1000);
        do_feed(); idle(1000);
        check("R5 refresh irq", 32'(wdt_irq), 0);

        // R7, R11 expiry in interrupt mode
        bus_write(A_TC, 32'h100);
        do_feed();
        idle(1027);
        check("R7 before expiry", 32'(wdt_irq), 0);
        idle(1);
        check("R7 at expiry", 32'(wdt_irq), 1);
        check("R11 no reset req", 32'(chip_rst_req), 0);
        bus_read(A_MODE, v); check("R9 flag set enable cleared", v, 32'h4);
        bus_read(A_VAL, v);  check("R9 value frozen", v, 0);
        bus_write(A_MODE, 32'h4);
        bus_read(A_MODE, v); check("R11 flag cleared", v, 0);
        check("R11 irq cleared", 32'(wdt_irq), 0);

        // R8 access between key writes
        bus_write(A_MODE, 32'h1);
        do_feed();
        bus_write(A_FEED, 32'hAA);
        bus_read(A_TC, v);
        check("R8 read between keys", 32'(wdt_irq), 1);
        bus_read(A_MODE, v); check("R9 enable cleared by bad feed", v, 32'h4);
        bus_write(A_MODE, 32'h4);

        // R8 wrong second key
        bus_write(A_MODE, 32'h1);
        bus_write(A_FEED, 32'hAA);
        bus_write(A_FEED, 32'h56);
        check("R8 wrong second key", 32'(wdt_irq), 1);
        bus_write(A_MODE, 32'h4);

        // R8 doubled first key
        bus_write(A_MODE, 32'h1);
        bus_write(A_FEED, 32'hAA);
        bus_write(A_FEED, 32'hAA);
        check("R8 doubled first key", 32'(wdt_irq), 1);
        bus_write(A_MODE, 32'h4);

        // R8 second key without first
        bus_write(A_MODE, 32'h1);
        bus_write(A_FEED, 32'h55);
        check("R8 unarmed write", 32'(wdt_irq), 1);
        bus_write(A_MODE, 32'h4);

        // R10, R12 reset mode
        bus_write(A_MODE, 32'h3);
        bus_write(A_TC, 32'h0);
        do_feed();
        idle(1023);
        check("R10 before expiry", 32'(chip_rst_req), 0);
        idle(1);
        check("R10 reset request", 32'(chip_rst_req), 1);
        check("R10 irq low", 32'(wdt_irq), 0);
        idle(1);
        check("R10 single pulse", 32'(chip_rst_req), 0);
        check("R12 flag pin kept", 32'(timeout_flag), 1);
        idle(20);
        bus_read(A_MODE, v); check("R12 flag kept", v, 32'h6);
        bus_write(A_MODE, 32'h4);
        bus_read(A_MODE, v); check("R12 software clear", v, 0);

        // Random rounds
        for (int it = 0; it < 16; it++) begin
            logic [31:0] tcw;
            logic [31:0] tc;
            int n;
            tcw = 32'($urandom % 800);
            tc  = exp_tc(tcw);
            bus_write(A_MODE, 32'h1);
            bus_write(A_TC, tcw);
            do_feed();
            n = int'($urandom % (4 * tc));
            idle(n);
            bus_read(A_VAL, v);
            check("R6 random value", v, exp_val(tc, n));
            check("R6 no early fault", 32'(timeout_flag), 0);
            if ($urandom % 2 == 0) begin
                bus_write(A_FEED, 32'hAA);
                bus_read(A_VAL, v);
                check("R8 random bad feed", 32'(wdt_irq), 1);
            end else begin
                idle(int'(4 * (tc + 1)) - (n + 1) - 1);
                check("R7 random before expiry", 32'(timeout_flag), 0);
                idle(1);
                check("R7 random expiry", 32'(timeout_flag), 1);
            end
            bus_write(A_MODE, 32'h4);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule